// File: doc/BRIEF.md
# Dual-Layer Video Priority Mixer

This block merges the pixel-index streams of two video display controllers into a single 9-bit colour index for a downstream colour encoder. Each source supplies one index per dot. Bit 8 flags a sprite pixel, which addresses the upper half of the palette. The low bits carry the colour number. A source that has nothing to show drives sprite colour zero, and the mixer reads that as an absent pixel. A background pixel with colour number zero is see-through, so the layer beneath it shows.

The line is cut into four regions by two windows. Each window is set by a single width, counted from the left edge of the line. The four regions are: outside both windows, inside only the first, inside only the second, and inside both. Each region has its own 4-bit setting that enables each source and selects how the sprites of the two sources are ordered. The background order never changes: the first source's background is always above the second's. One ordering sends the first source's sprites behind both backgrounds. In that ordering, a sprite that its own controller marked as above its background punches a backdrop-coloured hole.

A host writes the window widths and region settings at any time. The new values take effect at the start of the next line. All logic advances on the shared dot-clock enable, and the merged index is registered with one dot of latency.

Top module: `vid_layer_mixer`

## Requirements
- R1: The index 9'h100 on either source means that source has no pixel at that dot. An index with bit 8 clear is a background pixel, and it is see-through when its low 8 bits are zero. Any other index with bit 8 set is a visible sprite pixel.
- R2: When both sources show background pixels, the first source (pix_a) always wins over the second source (pix_b), whatever the region setting.
- R3: The dot counter restarts at 0 on the dot that carries line_start and counts up by one on every later dot_en. A dot is inside window n when the counter is less than width_n − 64. The region index is {in window 2, in window 1}, so 0 means neither, 1 means first only, 2 means second only and 3 means both.
- R4: A window width below 64 disables that window. A width of exactly 64 contains no dot.
- R5: Region setting mode 2'b00 (setting bits 3:2) shows a visible first-source pixel above anything from the second source.
- R6: In mode 2'b01, a visible sprite from the first source wins first, then a visible sprite from the second source, then the first background, then the second background.
- R7: In mode 2'b10, a visible first-source background wins, then any visible second-source pixel, and a first-source sprite shows only when nothing else does.
- R8: In mode 2'b10, a visible first-source sprite that comes with a_spr_over_bg high produces output 9'h000, whatever the second source shows.
- R9: Mode 2'b11 behaves exactly as mode 2'b00.
- R10: Setting bit 0 enables the first source and bit 1 enables the second. A disabled source is treated as having no pixel.
- R11: When neither enabled source supplies a visible pixel, the output is the backdrop index 9'h000.
- R12: Register writes use reg_addr as follows: 0 sets window 1 width, 1 sets window 2 width, 2 sets region 0 (bits 3:0) and region 1 (bits 7:4), and 3 sets region 2 (bits 3:0) and region 3 (bits 7:4). A write takes effect from the next line_start dot; dots earlier in the current line keep the old values.
- R13: The output takes the mixed value of a dot at the clock edge where dot_en is high, so it changes one dot later. While dot_en is low, both the output and the dot counter hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Shared dot-clock enable |
| line_start | input | 1 | Marks the first dot of a line (sampled with dot_en) |
| pix_a | input | 9 | Pixel index from the first controller |
| pix_b | input | 9 | Pixel index from the second controller |
| a_spr_over_bg | input | 1 | First source's sprite is flagged above its own background |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 10 | Host write data |
| pix_out | output | 9 | Merged colour index to the encoder |

## Verification
The bench builds the mixer with its default parameters: a 10-bit dot counter, a window base of 64 and line-start shadowing of the registers turned on. With a base of 64, widths just above it put window edges a few dots into the line. Short lines then reach all four regions and both sides of each window edge. Shadowing makes it possible to write a register mid-line and observe that the current line keeps the old ordering while the next line uses the new one.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

   localparam int NUM_WIN     = 2;
   localparam int NUM_REGIONS = 1 << NUM_WIN;

   typedef enum logic [1:0] {
      MODE_A_TOP    = 2'b00,
      MODE_B_SPR_UP = 2'b01,
      MODE_A_SPR_BK = 2'b10,
      MODE_RSVD     = 2'b11
   } mix_mode_e;

   // one region's setting: {mode[1:0], en_b, en_a}
   typedef struct packed {
      logic [1:0] mode;
      logic       en_b;
      logic       en_a;
   } region_cfg_t;

   typedef struct packed {
      logic none;
      logic bg;
      logic spr;
   } pix_class_t;

endpackage

// File: rtl/vlm_classify.sv
module vlm_classify
   import vlm_pkg::*;
#(
   parameter int PIX_W = 9
)(
   input  logic [PIX_W-1:0] pix_i,
   input  logic             en_i,
   output pix_class_t       cls_o
);

   localparam logic [PIX_W-1:0] NO_PIX = {1'b1, {(PIX_W-1){1'b0}}};

   logic             is_spr;
   logic             colour_nz;
   logic             absent;

   initial begin : param_chk
      assert (PIX_W >= 2) else $error("vlm_classify: PIX_W must be at least 2");
   end

   always_comb begin
      is_spr    = pix_i[PIX_W-1];
      colour_nz = |pix_i[PIX_W-2:0];
      absent    = (pix_i == NO_PIX) || !en_i;
      cls_o.none = absent;
      cls_o.spr  = !absent && is_spr && colour_nz;
      cls_o.bg   = !absent && !is_spr && colour_nz;
   end

endmodule

// File: rtl/vlm_regs.sv
module vlm_regs
   import vlm_pkg::*;
#(
   parameter int REG_W      = 10,
   parameter int HPOS_W     = 10,
   parameter int ADDR_W     = 2,
   parameter bit SHADOW_CFG = 1'b1
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [REG_W-1:0]                     wr_data,
   input  logic                                 line_go,
   output logic [NUM_WIN-1:0][HPOS_W-1:0]       win_w_o,
   output region_cfg_t [NUM_REGIONS-1:0]        cfg_o
);

   localparam int CFG_BITS  = $bits(region_cfg_t);
   localparam int PAIR_BITS = 2 * CFG_BITS;
   localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(NUM_WIN);
   localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(NUM_WIN + 1);
   localparam region_cfg_t CFG_RST = '{mode: MODE_A_TOP, en_b: 1'b1, en_a: 1'b1};

   initial begin : param_chk
      assert (REG_W >= PAIR_BITS) else $error("vlm_regs: REG_W too narrow for two region settings");
      assert (REG_W >= HPOS_W)    else $error("vlm_regs: REG_W narrower than a window width");
      assert ((1 << ADDR_W) >= NUM_WIN + 2) else $error("vlm_regs: ADDR_W too small");
   end

   logic [NUM_WIN-1:0][HPOS_W-1:0] sh_win;
   region_cfg_t [NUM_REGIONS-1:0]  sh_cfg;

   // host-side copy, written at any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_win <= '0;
         for (int r = 0; r < NUM_REGIONS; r++) sh_cfg[r] <= CFG_RST;
      end else if (wr_en) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (wr_addr == ADDR_W'(w)) sh_win[w] <= wr_data[HPOS_W-1:0];
         end
         if (wr_addr == A_CFG_LO) {sh_cfg[1], sh_cfg[0]} <= wr_data[PAIR_BITS-1:0];
         if (wr_addr == A_CFG_HI) {sh_cfg[3], sh_cfg[2]} <= wr_data[PAIR_BITS-1:0];
      end
   end

   generate
      if (SHADOW_CFG) begin : g_shadow
         logic [NUM_WIN-1:0][HPOS_W-1:0] act_win;
         region_cfg_t [NUM_REGIONS-1:0]  act_cfg;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_win <= '0;
               for (int r = 0; r < NUM_REGIONS; r++) act_cfg[r] <= CFG_RST;
            end else if (line_go) begin
               act_win <= sh_win;
               act_cfg <= sh_cfg;
            end
         end

         // the line-start dot already sees the new values
         assign win_w_o = line_go ? sh_win : act_win;
         assign cfg_o   = line_go ? sh_cfg : act_cfg;

         AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !line_go |=> ($stable(act_cfg) && $stable(act_win))); // R12
      end else begin : g_direct
         assign win_w_o = sh_win;
         assign cfg_o   = sh_cfg;
      end
   endgenerate

endmodule

// File: rtl/vlm_hpos.sv
module vlm_hpos
   import vlm_pkg::*;
#(
   parameter int HPOS_W   = 10,
   parameter int WIN_BASE = 64
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            dot_en,
   input  logic                            line_start,
   input  logic [NUM_WIN-1:0][HPOS_W-1:0]  win_w_i,
   output logic [NUM_WIN-1:0]              in_win_o
);

   localparam logic [HPOS_W-1:0] BASE   = HPOS_W'(WIN_BASE);
   localparam logic [HPOS_W-1:0] CNT_MX = '1;

   initial begin : param_chk
      assert (WIN_BASE > 0 && WIN_BASE < (1 << HPOS_W))
         else $error("vlm_hpos: WIN_BASE must fit inside HPOS_W");
   end

   logic [HPOS_W-1:0] cnt;
   logic [HPOS_W-1:0] pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (dot_en) begin
         if (line_start)         cnt <= HPOS_W'(1);
         else if (cnt != CNT_MX) cnt <= cnt + 1'b1;
      end
   end

   assign pos = line_start ? '0 : cnt;

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         logic armed;
         logic [HPOS_W-1:0] span;
         assign armed       = (win_w_i[w] >= BASE);
         assign span        = win_w_i[w] - BASE;
         assign in_win_o[w] = armed && (pos < span);
      end
   endgenerate

   AST_HPOS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && line_start) |=> (cnt == HPOS_W'(1))); // R3
   AST_HPOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !dot_en |=> $stable(cnt)); // R13
   AST_WIN_FIRST_DOT: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && in_win_o[0]) |-> (win_w_i[0] > BASE)); // R4

endmodule

// File: rtl/vlm_prio.sv
module vlm_prio
   import vlm_pkg::*;
#(
   parameter int PIX_W = 9
)(
   input  logic [PIX_W-1:0] pix_a_i,
   input  logic [PIX_W-1:0] pix_b_i,
   input  pix_class_t       cls_a_i,
   input  pix_class_t       cls_b_i,
   input  logic             a_over_i,
   input  logic [1:0]       mode_i,
   output logic [PIX_W-1:0] mix_o
);

   logic a_vis, b_vis;

   always_comb begin
      a_vis = cls_a_i.bg || cls_a_i.spr;
      b_vis = cls_b_i.bg || cls_b_i.spr;
      mix_o = '0;
      unique case (mode_i)
         MODE_B_SPR_UP: begin
            if (cls_a_i.spr)      mix_o = pix_a_i;
            else if (cls_b_i.spr) mix_o = pix_b_i;
            else if (cls_a_i.bg)  mix_o = pix_a_i;
            else if (cls_b_i.bg)  mix_o = pix_b_i;
         end
         MODE_A_SPR_BK: begin
            if (cls_a_i.spr && a_over_i) mix_o = '0;
            else if (cls_a_i.bg)         mix_o = pix_a_i;
            else if (b_vis)              mix_o = pix_b_i;
            else if (cls_a_i.spr)        mix_o = pix_a_i;
         end
         default: begin
            if (a_vis)      mix_o = pix_a_i;
            else if (b_vis) mix_o = pix_b_i;
         end
      endcase
   end

endmodule

// File: rtl/vid_layer_mixer.sv
module vid_layer_mixer
   import vlm_pkg::*;
#(
   parameter int PIX_W      = 9,
   parameter int HPOS_W     = 10,
   parameter int REG_W      = 10,
   parameter int ADDR_W     = 2,
   parameter int WIN_BASE   = 64,
   parameter bit SHADOW_CFG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dot_en,
   input  logic              line_start,
   input  logic [PIX_W-1:0]  pix_a,
   input  logic [PIX_W-1:0]  pix_b,
   input  logic              a_spr_over_bg,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [PIX_W-1:0]  pix_out
);

   localparam logic [PIX_W-1:0] NO_PIX = {1'b1, {(PIX_W-1){1'b0}}};

   logic                           line_go;
   logic [NUM_WIN-1:0][HPOS_W-1:0] win_w;
   region_cfg_t [NUM_REGIONS-1:0]  cfg_all;
   logic [NUM_WIN-1:0]             in_win;
   region_cfg_t                    cfg_cur;
   pix_class_t                     cls [2];
   logic [PIX_W-1:0]               src_pix [2];
   logic [1:0]                     src_en;
   logic [PIX_W-1:0]               mix;

   assign line_go = dot_en && line_start;

   vlm_regs #(
      .REG_W(REG_W), .HPOS_W(HPOS_W), .ADDR_W(ADDR_W), .SHADOW_CFG(SHADOW_CFG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .line_go(line_go), .win_w_o(win_w), .cfg_o(cfg_all)
   );

   vlm_hpos #(
      .HPOS_W(HPOS_W), .WIN_BASE(WIN_BASE)
   ) u_hpos (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line_start(line_start),
      .win_w_i(win_w), .in_win_o(in_win)
   );

   // region index = {in window 2, in window 1}
   assign cfg_cur    = cfg_all[in_win];
   assign src_pix[0] = pix_a;
   assign src_pix[1] = pix_b;
   assign src_en     = {cfg_cur.en_b, cfg_cur.en_a};

   generate
      for (genvar s = 0; s < 2; s++) begin : g_src
         vlm_classify #(.PIX_W(PIX_W)) u_cls (
            .pix_i(src_pix[s]), .en_i(src_en[s]), .cls_o(cls[s])
         );
      end
   endgenerate

   vlm_prio #(.PIX_W(PIX_W)) u_prio (
      .pix_a_i(pix_a), .pix_b_i(pix_b), .cls_a_i(cls[0]), .cls_b_i(cls[1]),
      .a_over_i(a_spr_over_bg), .mode_i(cfg_cur.mode), .mix_o(mix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      pix_out <= '0;
      else if (dot_en) pix_out <= mix;
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !dot_en |=> $stable(pix_out)); // R13
   AST_BACKDROP: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && pix_a == NO_PIX && pix_b == NO_PIX) |=> (pix_out == '0)); // R11
   AST_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && cfg_cur.mode == MODE_A_SPR_BK && cfg_cur.en_a && pix_a[PIX_W-1]
       && pix_a != NO_PIX && a_spr_over_bg) |=> (pix_out == '0)); // R8
   AST_OUT_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
      dot_en |=> (pix_out == '0 || pix_out == $past(pix_a) || pix_out == $past(pix_b))); // R1
   AST_BG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && cfg_cur.en_a && !pix_a[PIX_W-1] && pix_a != '0 && !pix_b[PIX_W-1])
      |=> (pix_out == $past(pix_a))); // R2

endmodule

// File: tb/vid_layer_mixer_bench.sv
module vid_layer_mixer_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [8:0] NP = 9'h100;

   typedef struct packed {
      logic [9:0]  w1;
      logic [9:0]  w2;
      logic [15:0] s;     // {region3, region2, region1, region0}
      logic [9:0]  pos;
      logic [8:0]  pa;
      logic [8:0]  pb;
      logic        ov;
      logic [8:0]  ex;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{10'h048, 10'h044, 16'h0003, 10'd10, 9'h012, 9'h155, 1'b0, 9'h012, 4'd5},
      '{10'h048, 10'h044, 16'h0003, 10'd10, 9'h1A0, 9'h020, 1'b0, 9'h1A0, 4'd5},
      '{10'h048, 10'h044, 16'h0003, 10'd10, 9'h100, 9'h033, 1'b0, 9'h033, 4'd1},
      '{10'h048, 10'h044, 16'h0003, 10'd10, 9'h000, 9'h144, 1'b0, 9'h144, 4'd1},
      '{10'h048, 10'h044, 16'h0003, 10'd10, 9'h100, 9'h100, 1'b0, 9'h000, 4'd11},
      '{10'h048, 10'h044, 16'h0003, 10'd10, 9'h000, 9'h000, 1'b0, 9'h000, 4'd11},
      '{10'h048, 10'h044, 16'h0070, 10'd6,  9'h012, 9'h155, 1'b0, 9'h155, 4'd6},
      '{10'h048, 10'h044, 16'h0070, 10'd6,  9'h1A0, 9'h155, 1'b0, 9'h1A0, 4'd6},
      '{10'h048, 10'h044, 16'h0070, 10'd6,  9'h012, 9'h034, 1'b0, 9'h012, 4'd2},
      '{10'h048, 10'h044, 16'hB000, 10'd2,  9'h1A0, 9'h034, 1'b0, 9'h034, 4'd7},
      '{10'h048, 10'h044, 16'hB000, 10'd2,  9'h1A0, 9'h100, 1'b0, 9'h1A0, 4'd7},
      '{10'h048, 10'h044, 16'hB000, 10'd2,  9'h1A0, 9'h034, 1'b1, 9'h000, 4'd8},
      '{10'h048, 10'h044, 16'hB000, 10'd2,  9'h012, 9'h155, 1'b0, 9'h012, 4'd7},
      '{10'h03F, 10'h048, 16'h0100, 10'd2,  9'h100, 9'h034, 1'b0, 9'h000, 4'd10},
      '{10'h03F, 10'h048, 16'h0200, 10'd2,  9'h012, 9'h034, 1'b0, 9'h034, 4'd10},
      '{10'h048, 10'h044, 16'h000F, 10'd10, 9'h012, 9'h155, 1'b0, 9'h012, 4'd9},
      '{10'h048, 10'h03F, 16'h0073, 10'd7,  9'h012, 9'h155, 1'b0, 9'h155, 4'd3},
      '{10'h048, 10'h03F, 16'h0073, 10'd8,  9'h012, 9'h155, 1'b0, 9'h012, 4'd3},
      '{10'h040, 10'h03F, 16'h0073, 10'd0,  9'h012, 9'h155, 1'b0, 9'h012, 4'd4}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       dot_en;
   logic       line_start;
   logic [8:0] pix_a;
   logic [8:0] pix_b;
   logic       a_spr_over_bg;
   logic       reg_wr;
   logic [1:0] reg_addr;
   logic [9:0] reg_wdata;
   logic [8:0] pix_out;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_layer_mixer u_vid_layer_mixer (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line_start(line_start),
      .pix_a(pix_a), .pix_b(pix_b), .a_spr_over_bg(a_spr_over_bg),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .pix_out(pix_out)
   );

   function automatic string req_name(input logic [3:0] n);
      case (n)
         4'd1:    return "R1";
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd9:    return "R9";
         4'd10:   return "R10";
         4'd11:   return "R11";
         4'd12:   return "R12";
         default: return "R13";
      endcase
   endfunction

   task automatic check(input string rq, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: pix_out=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic idle_inputs();
      line_start    = 1'b0;
      pix_a         = NP;
      pix_b         = NP;
      a_spr_over_bg = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [9:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic setup(input logic [9:0] w1, input logic [9:0] w2, input logic [15:0] s);
      reg_write(2'd0, w1);
      reg_write(2'd1, w2);
      reg_write(2'd2, {2'b00, s[7:0]});
      reg_write(2'd3, {2'b00, s[15:8]});
   endtask

   // starts a line, presents the pixel at dot 'pos', returns just after it is registered
   task automatic drive_line_to(input int pos, input logic [8:0] a, input logic [8:0] b,
                                input logic ov);
      for (int k = 0; k <= pos; k++) begin
         @(negedge clk);
         dot_en        = 1'b1;
         line_start    = (k == 0);
         pix_a         = (k == pos) ? a : NP;
         pix_b         = (k == pos) ? b : NP;
         a_spr_over_bg = (k == pos) ? ov : 1'b0;
      end
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      rst_n = 1'b0; dot_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      idle_inputs();
      pix_a = 9'h012;
      repeat (3) @(negedge clk);
      check("R11 reset", pix_out, 9'h000);
      rst_n = 1'b1;
      pix_a = NP;
      dot_en = 1'b1;

      // vector table
      for (int i = 0; i < NV; i++) begin
         setup(VECS[i].w1, VECS[i].w2, VECS[i].s);
         drive_line_to(int'(VECS[i].pos), VECS[i].pa, VECS[i].pb, VECS[i].ov);
         check(req_name(VECS[i].rq), pix_out, VECS[i].ex);
      end

      // R12: mid-line write does not change the current line
      setup(10'h03F, 10'h03F, 16'h0003);
      for (int k = 0; k <= 5; k++) begin
         @(negedge clk);
         line_start = (k == 0);
         if (k == 2) begin reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 10'h077; end
         else reg_wr = 1'b0;
         pix_a = (k == 5) ? 9'h012 : NP;
         pix_b = (k == 5) ? 9'h155 : NP;
      end
      @(negedge clk);
      idle_inputs();
      check("R12 old line", pix_out, 9'h012);
      drive_line_to(0, 9'h012, 9'h155, 1'b0);
      check("R12 next line", pix_out, 9'h155);

      // R13: dots with dot_en low neither advance the counter nor change the output
      setup(10'h042, 10'h03F, 16'h0073);
      @(negedge clk); line_start = 1'b1; dot_en = 1'b1;
      @(negedge clk); line_start = 1'b0; dot_en = 1'b0;
      @(negedge clk);
      @(negedge clk); dot_en = 1'b1; pix_a = 9'h012; pix_b = 9'h155;
      @(negedge clk); dot_en = 1'b0; idle_inputs();
      check("R13 counter held", pix_out, 9'h155);
      @(negedge clk);
      check("R13 output held", pix_out, 9'h155);
      dot_en = 1'b1;
      @(negedge clk);
      check("R11 after hold", pix_out, 9'h000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule